// File: doc/BRIEF.md
# Byte-Granular Fuse Word Reader

This block sits in front of a one-time-programmable fuse macro that returns 32 bits per word address, and it serves read requests given as a byte offset and a byte count. A request sets the word span to read. The first word is the offset divided by four, rounded down. The span ends at the word boundary at or after offset plus length. The block then raises the macro's control lines in the required order and strobes each word once. From every sampled word it emits only the requested bytes, one byte per cycle, as a stream with a last marker.

Each word is captured at the end of its strobe window. Its bytes are released after the strobe has been cleared. The leading bytes of the first word that lie below the offset are dropped, and so are the bytes of the final word that lie past the end of the request. When the last word is done, the macro is put back into its low-power standby encoding and a one-cycle completion pulse is raised. Timing between control changes is one settle interval, given in clock cycles.

Top module: `fuse_word_reader`

## Requirements
- R1: Out of reset and whenever idle, `fuse_ctrl` equals 0x00000021 (power-down bit 5 and chip-select-bar bit 0 high), `busy` is low and `out_valid` and `done` are low.
- R2: A request is taken only when `req_valid` is high while `busy` is low; a `req_valid` pulse during a busy read has no effect on the addresses strobed or the bytes emitted.
- R3: A non-empty request starts with exactly SETTLE_CYC cycles of `fuse_ctrl` = 0x0000028C (load bit 2, program-enable-bar bit 3, read-sense-bar bit 7, strobe-shift-select bit 9) before the first strobe.
- R4: The strobed word addresses appear in `fuse_ctrl[25:16]`. They run consecutively, modulo 1024, from offset/4 up to ceil((offset+length)/4)-1, one strobe per word.
- R5: Each strobe (bit 1) is held high for exactly SETTLE_CYC cycles with a stable address and program-enable-bar high, and the word is captured while it is high. At least SETTLE_CYC cycles with strobe low separate two strobes.
- R6: Output byte k equals byte lane (offset+k) mod 4 of word (offset+k)/4, with lane 0 at bits 7:0. Leading lanes before the offset and lanes past the end are never emitted.
- R7: Exactly `req_len` bytes are emitted with `out_valid`, and `out_last` is high on the final byte only.
- R8: After the last word, `fuse_ctrl` returns to 0x00000021 in the cycle where `done` pulses for one cycle, and `busy` is low in the next cycle.
- R9: A request of length zero performs no initial phase and no strobe, and it goes straight to standby with its `done` pulse.
- R10: `out_valid` is never high while the strobe bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request pulse, taken when idle |
| req_offset | input | 12 | Byte offset of the first requested byte |
| req_len | input | 12 | Number of bytes requested |
| busy | output | 1 | High from acceptance until standby is done |
| done | output | 1 | One-cycle completion pulse |
| out_valid | output | 1 | Output byte is valid this cycle |
| out_byte | output | 8 | Output byte |
| out_last | output | 1 | Marks the final byte of the request |
| fuse_ctrl | output | 32 | Control word to the fuse macro |
| fuse_dout | input | 32 | Word returned by the fuse macro |

## Verification
The bench reads a word-array model through the control word. It tries an aligned single word, a span trimmed at both ends inside one word, a single byte, a span across three words with both ends trimmed, a four-word aligned span, and a span that wraps the 10-bit address. Aligned cases show that whole words pass through. Trimmed and single-byte cases separate the skip count of the first word from the tail cut of the last. The wrapping case shows the address arithmetic modulo 1024. A zero-length request and a request pulse injected during a busy read show that no strobe happens in the first case and that the injected pulse changes nothing.

// File: rtl/fwr_pkg.sv
package fwr_pkg;
  localparam int CB_CSB    = 0;
  localparam int CB_STROBE = 1;
  localparam int CB_LOAD   = 2;
  localparam int CB_PGENB  = 3;
  localparam int CB_PD     = 5;
  localparam int CB_RSB    = 7;
  localparam int CB_SSS    = 9;
  localparam int ADDR_LSB  = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_STROBE, ST_EMIT, ST_GAP, ST_STANDBY
  } fwr_state_e;

  // word index holding a byte offset
  function automatic int unsigned first_word(int unsigned off);
    return off >> 2;
  endfunction

  // bytes skipped at the front of the first word
  function automatic int unsigned lead_skip(int unsigned off);
    return off & 3;
  endfunction

  // number of words covering [off, off+len)
  function automatic int unsigned word_span(int unsigned off, int unsigned len);
    if (len == 0) return 0;
    return ((off + len + 3) >> 2) - (off >> 2);
  endfunction

  // control word for a given sequencer state
  function automatic logic [31:0] ctrl_word(fwr_state_e st, logic [15:0] addr);
    logic [31:0] c;
    c = '0;
    case (st)
      ST_INIT: begin
        c[CB_LOAD] = 1'b1; c[CB_PGENB] = 1'b1; c[CB_RSB] = 1'b1; c[CB_SSS] = 1'b1;
      end
      ST_STROBE, ST_EMIT, ST_GAP: begin
        c[CB_LOAD] = 1'b1; c[CB_PGENB] = 1'b1; c[CB_RSB] = 1'b1; c[CB_SSS] = 1'b1;
        c[ADDR_LSB +: 16] = addr;
        c[CB_STROBE] = (st == ST_STROBE);
      end
      default: begin
        c[CB_PD] = 1'b1; c[CB_CSB] = 1'b1;
      end
    endcase
    return c;
  endfunction
endpackage

// File: rtl/fwr_settle_timer.sv
module fwr_settle_timer #(
  parameter int SETTLE_CYC = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic elapsed
);
  localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign elapsed = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run || elapsed)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fwr_lane_pick.sv
module fwr_lane_pick #(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0]         word,
  input  logic [$clog2(LANES)-1:0]   lane,
  output logic [7:0]                 byte_o
);
  logic [7:0] lanes_w [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes_w[g] = word[g*8 +: 8];
  end

  assign byte_o = lanes_w[lane];
endmodule

// File: rtl/fwr_seq.sv
module fwr_seq
  import fwr_pkg::*;
#(
  parameter int AW    = 10,
  parameter int OFF_W = 12,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [OFF_W-1:0] req_offset,
  input  logic [LEN_W-1:0] req_len,
  input  logic             elapsed,
  input  logic [31:0]      fuse_dout,
  output logic             timer_run,
  output logic             word_cap,
  output logic             emit,
  output logic             emit_last,
  output logic [1:0]       lane,
  output logic [31:0]      word_q,
  output logic             busy,
  output logic             done,
  output logic [31:0]      ctrl
);
  localparam int WC_W = LEN_W + 1;

  fwr_state_e       st_q;
  logic [AW-1:0]    addr_q;
  logic [1:0]       lane_q;
  logic [LEN_W-1:0] bytes_left_q;
  logic [WC_W-1:0]  words_left_q;

  assign timer_run = (st_q == ST_INIT) || (st_q == ST_STROBE) || (st_q == ST_GAP);
  assign word_cap  = (st_q == ST_STROBE) && elapsed;
  assign emit      = (st_q == ST_EMIT);
  assign emit_last = emit && (bytes_left_q == LEN_W'(1));
  assign lane      = lane_q;
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_STANDBY);
  assign ctrl      = ctrl_word(st_q, 16'(addr_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      addr_q       <= '0;
      lane_q       <= '0;
      bytes_left_q <= '0;
      words_left_q <= '0;
      word_q       <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid) begin
          addr_q       <= AW'(first_word(32'(req_offset)));
          lane_q       <= 2'(lead_skip(32'(req_offset)));
          bytes_left_q <= req_len;
          words_left_q <= WC_W'(word_span(32'(req_offset), 32'(req_len)));
          st_q         <= (req_len == '0) ? ST_STANDBY : ST_INIT;
        end
        ST_INIT: if (elapsed) st_q <= ST_STROBE;
        ST_STROBE: if (elapsed) begin
          word_q       <= fuse_dout;
          words_left_q <= words_left_q - 1'b1;
          st_q         <= ST_EMIT;
        end
        ST_EMIT: begin
          bytes_left_q <= bytes_left_q - 1'b1;
          lane_q       <= lane_q + 1'b1;
          if (lane_q == 2'd3 || bytes_left_q == LEN_W'(1)) begin
            lane_q <= '0;
            st_q   <= ST_GAP;
          end
        end
        ST_GAP: if (elapsed) begin
          addr_q <= addr_q + 1'b1;
          st_q   <= (words_left_q == '0) ? ST_STANDBY : ST_STROBE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fuse_word_reader.sv
module fuse_word_reader #(
  parameter int AW         = 10,
  parameter int OFF_W      = 12,
  parameter int LEN_W      = 12,
  parameter int SETTLE_CYC = 125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [OFF_W-1:0] req_offset,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             out_last,
  output logic [31:0]      fuse_ctrl,
  input  logic [31:0]      fuse_dout
);
  logic        timer_run;
  logic        elapsed;
  logic        word_cap;
  logic        emit;
  logic        emit_last;
  logic [1:0]  lane;
  logic [31:0] word_q;

  fwr_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(timer_run), .elapsed(elapsed)
  );

  fwr_seq #(.AW(AW), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
    .req_len(req_len), .elapsed(elapsed), .fuse_dout(fuse_dout),
    .timer_run(timer_run), .word_cap(word_cap), .emit(emit), .emit_last(emit_last),
    .lane(lane), .word_q(word_q), .busy(busy), .done(done), .ctrl(fuse_ctrl)
  );

  fwr_lane_pick #(.LANES(4)) u_pick (
    .word(word_q), .lane(lane), .byte_o(out_byte)
  );

  assign out_valid = emit;
  assign out_last  = emit_last;
endmodule

// File: rtl/fwr_checker.sv
module fwr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        out_valid,
  input logic        out_last,
  input logic        word_cap,
  input logic [31:0] fuse_ctrl
);
  assert_idle_ctrl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fuse_ctrl == 32'h21) && !out_valid);

  assert_load_before_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fuse_ctrl[1]) |-> $past(fuse_ctrl[2]) && $past(fuse_ctrl[3]));

  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_ctrl[1] && $past(fuse_ctrl[1])) |-> fuse_ctrl[25:16] == $past(fuse_ctrl[25:16]));

  assert_strobe_pgenb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_ctrl[1] |-> fuse_ctrl[3] && !fuse_ctrl[5]);

  assert_capture_in_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_cap |-> fuse_ctrl[1]);

  assert_last_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_done_standby_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> fuse_ctrl == 32'h21);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_emit_strobe_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !fuse_ctrl[1]);
endmodule

bind fuse_word_reader fwr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .out_valid(out_valid),
  .out_last(out_last), .word_cap(word_cap), .fuse_ctrl(fuse_ctrl)
);

// File: tb/fuse_word_reader_tb.sv
`timescale 1ns/1ps
module fuse_word_reader_tb;
  localparam int SETTLE = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [11:0] req_offset = '0;
  logic [11:0] req_len = '0;
  logic        busy, done, out_valid, out_last;
  logic [7:0]  out_byte;
  logic [31:0] fuse_ctrl, fuse_dout;

  always #4 clk = ~clk;

  fuse_word_reader #(.SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
    .req_len(req_len), .busy(busy), .done(done), .out_valid(out_valid),
    .out_byte(out_byte), .out_last(out_last), .fuse_ctrl(fuse_ctrl),
    .fuse_dout(fuse_dout)
  );

  function automatic logic [31:0] model_word(int unsigned a);
    logic [7:0] b;
    b = 8'(a);
    return {b ^ 8'hA5, b + 8'd3, ~b, b ^ 8'(a >> 8) ^ 8'h5C};
  endfunction

  assign fuse_dout = fuse_ctrl[1] ? model_word(32'(fuse_ctrl[25:16])) : 32'h0;

  int checks = 0, fails = 0, cycles = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor state
  bit         collecting = 0;
  logic [7:0] got [64];
  int         nb, nlast, lastpos, na, init_cnt, done_cnt, st_w, gap;
  int         addrs [64];
  bit         width_bad, gap_bad, stand_ok, prev_strobe, valid_in_strobe;

  always @(negedge clk) begin
    cycles++;
    if (collecting) begin
      if (out_valid) begin
        if (nb < 64) got[nb] = out_byte;
        if (out_last) begin nlast++; lastpos = nb; end
        nb++;
        if (fuse_ctrl[1]) valid_in_strobe = 1;
      end
      if (fuse_ctrl[1] && !prev_strobe) begin
        if (na < 64) addrs[na] = int'(fuse_ctrl[25:16]);
        if (na > 0 && gap < SETTLE) gap_bad = 1;
        na++;
        st_w = 1;
      end else if (fuse_ctrl[1]) st_w++;
      if (!fuse_ctrl[1] && prev_strobe) begin
        if (st_w != SETTLE) width_bad = 1;
        gap = 1;
      end else if (!fuse_ctrl[1]) gap++;
      if (fuse_ctrl == 32'h28C && na == 0) init_cnt++;
      if (done) begin
        done_cnt++;
        if (fuse_ctrl != 32'h21) stand_ok = 0;
      end
    end
    prev_strobe = fuse_ctrl[1];
  end

  task automatic run_case(int off, int len, bit inject, string tag);
    int nw, ws, wait_c, exp_last;
    bit bytes_ok, addr_ok;
    nb = 0; nlast = 0; lastpos = -1; na = 0; init_cnt = 0; done_cnt = 0;
    st_w = 0; gap = 0; width_bad = 0; gap_bad = 0; stand_ok = 1; valid_in_strobe = 0;
    collecting = 1;
    @(negedge clk);
    req_offset = 12'(off); req_len = 12'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_c = 0;
    while (done_cnt == 0 && wait_c < 20000) begin
      if (inject && wait_c == 3) begin
        req_offset = 12'(off + 7); req_len = 12'(len + 2); req_valid = 1'b1;
      end else req_valid = 1'b0;
      @(negedge clk);
      wait_c++;
    end
    req_valid = 1'b0;
    check(done_cnt == 1, "R8", {tag, " done seen"}, done_cnt, 1);
    check(busy == 1'b0, "R8", {tag, " busy after done"}, int'(busy), 0);
    check(stand_ok, "R8", {tag, " standby ctrl at done"}, int'(stand_ok), 1);
    collecting = 0;
    ws = off / 4;
    nw = (len == 0) ? 0 : ((off + len + 3) / 4 - ws);
    check(na == nw, "R4", {tag, " strobe count"}, na, nw);
    addr_ok = 1;
    for (int i = 0; i < na && i < 64; i++)
      if (addrs[i] != (ws + i) % 1024) addr_ok = 0;
    check(addr_ok, "R4", {tag, " word addresses"}, na > 0 ? addrs[0] : -1, ws % 1024);
    check(init_cnt == (len == 0 ? 0 : SETTLE), len == 0 ? "R9" : "R3",
          {tag, " init phase cycles"}, init_cnt, len == 0 ? 0 : SETTLE);
    check(!width_bad && !gap_bad, "R5", {tag, " strobe width/gap"},
          int'(width_bad) * 2 + int'(gap_bad), 0);
    check(nb == len, "R7", {tag, " byte count"}, nb, len);
    exp_last = (len == 0) ? -1 : len - 1;
    check(nlast == (len > 0 ? 1 : 0) && lastpos == exp_last, "R7", {tag, " last flag position"},
          lastpos, exp_last);
    bytes_ok = 1;
    for (int k = 0; k < nb && k < 64; k++) begin
      logic [31:0] w;
      w = model_word(32'(((off + k) / 4) % 1024));
      if (got[k] != w[((off + k) % 4) * 8 +: 8]) begin
        bytes_ok = 0;
        $display("FAIL R6 %s byte %0d: actual=%0d expected=%0d", tag, k, got[k],
                 w[((off + k) % 4) * 8 +: 8]);
      end
    end
    check(bytes_ok, inject ? "R2" : "R6", {tag, " byte values"}, int'(bytes_ok), 1);
    check(!valid_in_strobe, "R10", {tag, " no byte during strobe"}, int'(valid_in_strobe), 0);
    check(fuse_ctrl == 32'h21, "R1", {tag, " idle ctrl"}, int'(fuse_ctrl), 32'h21);
  endtask

  task automatic check_reset();
    check(fuse_ctrl == 32'h21, "R1", "reset ctrl", int'(fuse_ctrl), 32'h21);
    check(!busy && !done && !out_valid, "R1", "reset outputs",
          int'({busy, done, out_valid}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset();
    run_case(8, 4, 0, "aligned_word");
    run_case(1, 2, 0, "inner_trim");
    run_case(2, 1, 0, "single_byte");
    run_case(3, 6, 0, "three_words");
    run_case(0, 16, 0, "four_words");
    run_case(4090, 12, 0, "addr_wrap");
    run_case(5, 0, 0, "zero_len_R9");
    run_case(6, 9, 1, "busy_ignore_R2");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule